// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog built around a 32-bit down-counter that ticks once per clock while enabled. Software arms it by loading a tick count and enabling it. It keeps the system alive by reloading the count before it runs out, which is the kick. Two events are reported on separate level outputs: an early warning when the count passes a programmed threshold, and a final timeout when the count reaches zero. The timeout output is meant to drive an external reset or recovery path.

Every register write must be preceded by an unlock key written to a dedicated key register. The key is good for one bus write only. Stray or corrupted writes therefore cannot stop, reload or retune the timer. Reads are never guarded, so software can poll the live remaining count at any time. Event status bits are cleared by writing ones to a status register, and that write is protected in the same way.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the count (0x00), threshold (0x04), enable (0x08) and status (0x10) registers read zero, both interrupt outputs are low, and the block is locked.
- R2: A write of 0xF1D0DEAD to the key register (0x0C) unlocks exactly the next bus write. Idle cycles between the key and that write keep the unlock. The next write consumes the unlock whatever its address, including an unmapped address or another key write.
- R3: A write to 0x00, 0x04, 0x08 or 0x10 that does not directly follow a valid key write is ignored. A wrong key value also leaves the block locked.
- R4: Writing 1 to bit 0 of the enable register (0x08) makes the count fall by one per clock. Writing 0 freezes the count, and re-enabling resumes from the frozen value.
- R5: A protected write to 0x00 loads the full 32-bit value into the counter, taking priority over the decrement (kick). Reading 0x00 returns the live count without any unlock.
- R6: While enabled with a nonzero threshold, status bit 8 sets on the clock edge at which the count equals the threshold. A threshold of zero never sets bit 8.
- R7: While enabled, status bit 9 sets on the clock edge at which the count is zero, and the count then holds at zero.
- R8: Status register 0x10 holds bit 8 (threshold) and bit 9 (timeout). A protected write clears each bit written as 1. A set event in the same cycle wins over the clear. The threshold output follows bit 8 and the timeout output follows bit 9.
- R9: The threshold and enable registers read back the last accepted protected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counter tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| thr_irq_o | output | 1 | Early-warning interrupt, level high |
| tmo_irq_o | output | 1 | Timeout interrupt, level high |

## Verification
A stuck or wrongly cleared unlock flag shows at the ports within two cycles: an unkeyed write changes a register's read value, or a keyed write is lost. A counter that misses a decrement or a load shows on the next read of 0x00. Reads are sampled every cycle during countdowns so that a one-cycle slip is caught. A wrong threshold or zero comparison moves the interrupt edge by at least one cycle, and the bench checks the exact cycle on each side of that edge.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam logic [7:0] OFS_CNT = 8'h00;
  localparam logic [7:0] OFS_THR = 8'h04;
  localparam logic [7:0] OFS_EN  = 8'h08;
  localparam logic [7:0] OFS_KEY = 8'h0C;
  localparam logic [7:0] OFS_STS = 8'h10;
  localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;
  localparam int STS_THR_BIT = 8;
  localparam int STS_TMO_BIT = 9;
  localparam int N_EVT = 2;
  typedef enum logic [0:0] {EVT_THR = 1'b0, EVT_TMO = 1'b1} evt_e;
endpackage

// File: rtl/wdog_key_gate.sv
`timescale 1ns/1ps
module wdog_key_gate #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          key_addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlocked_o
);
  import wdog_pkg::*;

  logic key_ok;
  assign key_ok = key_addr_i && (wdata_i == DW'(UNLOCK_KEY));

  // any write consumes the unlock; only a valid key re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlocked_o <= 1'b0;
    else if (we_i) unlocked_o <= key_ok;
  end

  p_idle_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(unlocked_o));
  p_non_key_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !key_addr_i) |=> !unlocked_o);
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] thr_i,
  output logic [DW-1:0] cnt_o,
  output logic          thr_hit_o,
  output logic          tmo_hit_o
);
  logic at_zero;
  assign at_zero = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (load_i)            cnt_o <= load_val_i;
    else if (en_i && !at_zero)  cnt_o <= cnt_o - 1'b1;
  end

  assign thr_hit_o = en_i && (thr_i != '0) && (cnt_o == thr_i);
  assign tmo_hit_o = en_i && at_zero;

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_o));
  p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero && !load_i) |=> (cnt_o == '0));
endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
module wdog_status #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_o[i] <= 1'b0;
      else if (set_i[i]) sts_o[i] <= 1'b1;
      else if (clr_i[i]) sts_o[i] <= 1'b0;
    end
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              thr_irq_o,
  output logic              tmo_irq_o
);
  import wdog_pkg::*;

  logic sel_cnt, sel_thr, sel_en, sel_key, sel_sts;
  assign sel_cnt = (addr_i == ADDR_W'(OFS_CNT));
  assign sel_thr = (addr_i == ADDR_W'(OFS_THR));
  assign sel_en  = (addr_i == ADDR_W'(OFS_EN));
  assign sel_key = (addr_i == ADDR_W'(OFS_KEY));
  assign sel_sts = (addr_i == ADDR_W'(OFS_STS));

  logic unlocked, wr_ok;
  wdog_key_gate #(.DW(DW)) i_key (
    .clk_i, .rst_ni, .we_i, .key_addr_i(sel_key), .wdata_i, .unlocked_o(unlocked)
  );
  assign wr_ok = we_i && unlocked;

  logic          en_q;
  logic [DW-1:0] thr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else if (wr_ok) begin
      if (sel_en)  en_q  <= wdata_i[0];
      if (sel_thr) thr_q <= wdata_i;
    end
  end

  logic [DW-1:0] cnt;
  logic          thr_hit, tmo_hit;
  wdog_counter #(.DW(DW)) i_cnt (
    .clk_i, .rst_ni, .en_i(en_q), .load_i(wr_ok && sel_cnt), .load_val_i(wdata_i),
    .thr_i(thr_q), .cnt_o(cnt), .thr_hit_o(thr_hit), .tmo_hit_o(tmo_hit)
  );

  logic [N_EVT-1:0] sts, evt_set, evt_clr;
  assign evt_set[EVT_THR] = thr_hit;
  assign evt_set[EVT_TMO] = tmo_hit;
  assign evt_clr[EVT_THR] = wr_ok && sel_sts && wdata_i[STS_THR_BIT];
  assign evt_clr[EVT_TMO] = wr_ok && sel_sts && wdata_i[STS_TMO_BIT];

  wdog_status #(.N(N_EVT)) i_sts (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(evt_clr), .sts_o(sts)
  );

  assign thr_irq_o = sts[EVT_THR];
  assign tmo_irq_o = sts[EVT_TMO];

  always_comb begin
    rdata_o = '0;
    if (sel_cnt) rdata_o = cnt;
    if (sel_thr) rdata_o = thr_q;
    if (sel_en)  rdata_o[0] = en_q;
    if (sel_sts) begin
      rdata_o[STS_THR_BIT] = sts[EVT_THR];
      rdata_o[STS_TMO_BIT] = sts[EVT_TMO];
    end
  end

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && sel_cnt) |=> (cnt == $past(wdata_i)));
  p_locked_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked && sel_en) |=> (en_q == $past(en_q)));
  p_thr_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_irq_o) |-> $past(en_q && thr_q != '0 && cnt == thr_q));
  p_tmo_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_irq_o) |-> $past(en_q && cnt == '0));
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam logic [7:0] A_CNT = 8'h00, A_THR = 8'h04, A_EN = 8'h08,
                         A_KEY = 8'h0C, A_STS = 8'h10, A_NONE = 8'h14;
  localparam logic [31:0] KEY = 32'hF1D0_DEAD;

  logic        clk = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        thr_irq_o, tmo_irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (.clk_i(clk), .rst_ni, .addr_i, .we_i, .wdata_i,
                           .rdata_o, .thr_irq_o, .tmo_irq_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic pw(logic [7:0] a, logic [31:0] d);
    wr(A_KEY, KEY);
    wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a; we_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic chk_rd(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk_rd("R1 cnt", A_CNT, 0);
    chk_rd("R1 thr", A_THR, 0);
    chk_rd("R1 en", A_EN, 0);
    chk_rd("R1 sts", A_STS, 0);
    chk("R1 irqs", {thr_irq_o, tmo_irq_o}, 0);
  endtask

  task automatic t_lock;
    wr(A_CNT, 55);
    chk_rd("R3 no key", A_CNT, 0);
    wr(A_KEY, 32'hDEAD_BEEF); wr(A_CNT, 55);
    chk_rd("R3 wrong key", A_CNT, 0);
    wr(A_KEY, KEY); wr(A_NONE, 1); wr(A_CNT, 55);
    chk_rd("R2 consumed by unmapped", A_CNT, 0);
    wr(A_KEY, KEY); wr(A_KEY, 32'h1234); wr(A_CNT, 55);
    chk_rd("R2 consumed by bad key", A_CNT, 0);
    wr(A_KEY, KEY);
    repeat (3) @(negedge clk);
    wr(A_CNT, 77);
    chk_rd("R2 idle keeps unlock", A_CNT, 77);
    wr(A_CNT, 88);
    chk_rd("R2 one shot", A_CNT, 77);
    wr(A_EN, 1);
    chk_rd("R3 en locked", A_EN, 0);
  endtask

  task automatic t_readback;
    pw(A_THR, 32'hABC);
    chk_rd("R9 thr", A_THR, 32'hABC);
    wr(A_THR, 1);
    chk_rd("R3 thr locked", A_THR, 32'hABC);
    pw(A_EN, 1);
    chk_rd("R9 en", A_EN, 1);
    pw(A_EN, 0);
    pw(A_THR, 0);
    pw(A_CNT, 32'hFFFF_FFFF);
    chk_rd("R5 full load", A_CNT, 32'hFFFF_FFFF);
    pw(A_EN, 1);
    @(negedge clk);
    chk_rd("R4 first tick", A_CNT, 32'hFFFF_FFFE);
    pw(A_EN, 0);
  endtask

  task automatic t_countdown;
    pw(A_STS, 32'h300); pw(A_THR, 4); pw(A_CNT, 10); pw(A_EN, 1);
    chk_rd("R4 start", A_CNT, 10);
    repeat (6) @(negedge clk);
    chk_rd("R4 live", A_CNT, 4);
    chk("R6 before", thr_irq_o, 0);
    @(negedge clk);
    chk("R6 thr set", thr_irq_o, 1);
    chk_rd("R6 sts", A_STS, 32'h100);
    repeat (3) @(negedge clk);
    chk_rd("R7 zero", A_CNT, 0);
    chk("R7 before", tmo_irq_o, 0);
    @(negedge clk);
    chk("R7 tmo set", tmo_irq_o, 1);
    repeat (2) @(negedge clk);
    chk_rd("R7 hold", A_CNT, 0);
    chk_rd("R8 both", A_STS, 32'h300);
    pw(A_STS, 32'h200);
    chk("R8 set wins", tmo_irq_o, 1);
  endtask

  task automatic t_w1c;
    pw(A_EN, 0);
    wr(A_STS, 32'h300);
    chk_rd("R8 unkeyed clear ignored", A_STS, 32'h300);
    pw(A_STS, 32'h200);
    chk_rd("R8 clear tmo", A_STS, 32'h100);
    chk("R8 irq lines", {thr_irq_o, tmo_irq_o}, 2'b10);
    pw(A_STS, 32'h100);
    chk_rd("R8 clear thr", A_STS, 0);
  endtask

  task automatic t_stop_resume;
    pw(A_THR, 0); pw(A_CNT, 20); pw(A_EN, 1);
    repeat (5) @(negedge clk);
    chk_rd("R4 run", A_CNT, 15);
    pw(A_EN, 0);
    chk_rd("R4 stopped", A_CNT, 13);
    repeat (4) @(negedge clk);
    chk_rd("R4 frozen", A_CNT, 13);
    pw(A_EN, 1);
    repeat (3) @(negedge clk);
    chk_rd("R4 resumed", A_CNT, 10);
    pw(A_EN, 0);
  endtask

  task automatic t_kick;
    pw(A_CNT, 6); pw(A_EN, 1);
    repeat (3) @(negedge clk);
    pw(A_CNT, 6);
    chk_rd("R5 kick", A_CNT, 6);
    repeat (3) @(negedge clk);
    pw(A_CNT, 6);
    repeat (2) @(negedge clk);
    chk("R5 no timeout", tmo_irq_o, 0);
    pw(A_EN, 0);
  endtask

  task automatic t_thr_zero;
    pw(A_THR, 0); pw(A_CNT, 3); pw(A_EN, 1);
    repeat (4) @(negedge clk);
    chk("R6 thr zero off", thr_irq_o, 0);
    chk("R7 tmo", tmo_irq_o, 1);
    pw(A_EN, 0);
    pw(A_STS, 32'h300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_readback();
    t_countdown();
    t_w1c();
    t_stop_resume();
    t_kick();
    t_thr_zero();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule